// File: doc/BRIEF.md
# Receive Cell Output Handshake

This block sits on the read side of a cell-buffering FIFO that runs in receive mode. It hands whole cells to a downstream sink over a 36-bit word bus, built as four 9-bit lanes. The internal buffer gives it a level signal that says at least one complete, not-yet-started cell is stored, and a show-ahead head word. The block returns a pop strobe for each word it presents.

Toward the sink, the block raises a cell-available flag and keeps it high for the whole cell. It presents one word per cycle while the sink's active-low enable allows it, and it marks the first word of each cell with a one-cycle start-of-cell pulse. The sink drives enable whenever it can take data and never waits for cell-available first. As a result, the first word comes out in the same cycle as cell-available rises if enable was already held. If cell-available came first, the first word comes out one cycle after enable goes active. The cell length in words and the lane geometry are parameters.

Top module: `cro_rx_cell_out`

## Requirements
- R1: While reset is active and right after it is released, rx_cav, rx_soc and src_pop are 0 and rx_data is all zeros.
- R2: When no cell is in progress, rx_cav rises in the cycle after a clock edge at which src_cell_rdy was sampled high.
- R3: rx_en_n is active low. A word is presented (rx_data carries src_word and src_pop is 1) only in a cycle in which rx_cav is 1, rx_en_n is 0, and rx_en_n was also 0 at the preceding clock edge. So if enable is already held, the first word appears in the very cycle that rx_cav rises.
- R4: If rx_cav is high before enable is asserted, nothing is presented in the cycle enable first goes low, and the first word appears in the next cycle.
- R5: rx_soc is 1 for exactly one cycle per cell, in the cycle that presents word 0 of that cell.
- R6: Raising rx_en_n in the middle of a cell stalls the transfer. No pop happens and rx_data is zero. The same pending word is presented, in order, once the R3 condition holds again.
- R7: Each cell is CELL_WORDS words (default 14) in buffer order, with exactly one src_pop per presented word.
- R8: After the last word of a cell, rx_cav drops unless src_cell_rdy is high at that edge. If it is high, rx_cav stays high and the next cell's word 0 follows with no gap while enable holds.
- R9: In any cycle with no presented word, rx_data is all zeros and rx_soc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_cell_rdy | input | 1 | Buffer holds at least one complete cell not yet started |
| src_word | input | DATA_W (36) | Show-ahead head word of the buffer |
| src_pop | output | 1 | Head word consumed this cycle |
| rx_en_n | input | 1 | Sink enable, active low |
| rx_data | output | DATA_W (36) | Output word bus, four 9-bit lanes |
| rx_soc | output | 1 | Start-of-cell marker on word 0 |
| rx_cav | output | 1 | Cell available |

## Verification
The bench checks both enable/cell-available orderings. A design that adds a register in the enable path would lose the same-cycle first word. A design that ignores enable history would send a word one cycle too early when cell-available leads. The bench stalls in the middle of a cell and checks that the word after the pause is the held one, not a skipped or repeated one, and that nothing leaks onto the bus during the pause. Back-to-back cells confirm that cell-available stays high and that the second start-of-cell lands exactly CELL_WORDS cycles after the first. A single cell confirms that the flag falls right after its last word instead of staying stuck high.

// File: rtl/cro_pkg.sv
package cro_pkg;

   // per-cycle transfer decision shared between stages
   typedef struct packed {
      logic xfer;   // a word is presented this cycle
      logic first;  // it is word 0 of a cell
      logic last;   // it is the final word of a cell
   } cro_flow_t;

endpackage

// File: rtl/cro_word_ctr.sv
module cro_word_ctr #(
   parameter int CELL_WORDS = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic first,
   output logic last
);
   localparam int IDX_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (step)
         idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
   end

   assign first = (idx == '0);
   assign last  = (idx == LAST_IDX);

   // a stalled cycle must keep the pending word position
   assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(idx));

   // position never leaves the cell range
   assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);
endmodule

// File: rtl/cro_avail.sv
module cro_avail (
   input  logic clk,
   input  logic rst_n,
   input  logic src_rdy,
   input  logic cell_done,
   output logic cav
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cav <= 1'b0;
      else if (!cav || cell_done)
         cav <= src_rdy;
   end

   assert_cav_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cav) |-> $past(src_rdy));

   assert_cav_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_done && !src_rdy) |=> !cav);

   assert_cav_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cav && !cell_done) |=> cav);
endmodule

// File: rtl/cro_lane_gate.sv
module cro_lane_gate #(
   parameter int LANE_W = 9
) (
   input  logic              pass,
   input  logic [LANE_W-1:0] din,
   output logic [LANE_W-1:0] dout
);
   assign dout = pass ? din : '0;
endmodule

// File: rtl/cro_rx_cell_out.sv
module cro_rx_cell_out #(
   parameter int CELL_WORDS = 14,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   localparam int DATA_W    = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_cell_rdy,
   input  logic [DATA_W-1:0] src_word,
   output logic              src_pop,
   input  logic              rx_en_n,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_soc,
   output logic              rx_cav
);
   import cro_pkg::*;

   generate
      if (CELL_WORDS < 2) begin : g_bad_len
         $error("CELL_WORDS must be at least 2");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("lane geometry must be non-empty");
      end
   endgenerate

   logic      en_seen;
   logic      w_first;
   logic      w_last;
   cro_flow_t flow;

   // enable sampled at the previous edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_seen <= 1'b0;
      else
         en_seen <= !rx_en_n;
   end

   always_comb begin
      flow.xfer  = rx_cav && en_seen && !rx_en_n;
      flow.first = flow.xfer && w_first;
      flow.last  = flow.xfer && w_last;
   end

   cro_word_ctr #(.CELL_WORDS(CELL_WORDS)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (flow.xfer),
      .first (w_first),
      .last  (w_last)
   );

   cro_avail u_avail (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_rdy   (src_cell_rdy),
      .cell_done (flow.last),
      .cav       (rx_cav)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         cro_lane_gate #(.LANE_W(LANE_W)) u_gate (
            .pass (flow.xfer),
            .din  (src_word[g*LANE_W +: LANE_W]),
            .dout (rx_data[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign src_pop = flow.xfer;
   assign rx_soc  = flow.first;

   assert_soc_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_soc |=> !rx_soc);

   assert_soc_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_soc |-> (!rx_en_n && $past(!rx_en_n)));

   assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !src_pop |-> (rx_data == '0 && !rx_soc));

   assert_pop_needs_cav_R3: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop |-> rx_cav);
endmodule

// File: tb/sim_cro_rx_cell_out.sv
module sim_cro_rx_cell_out;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 14;
   localparam int DW = 36;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_en_n = 1'b1;
   logic          src_pop, rx_soc, rx_cav;
   logic [DW-1:0] rx_data;
   logic [DW-1:0] src_word;
   logic          src_cell_rdy;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   // buffer model
   logic [DW-1:0] mem [0:127];
   int wr_ptr = 0, rd_ptr = 0, pop_idx = 0, unstarted = 0;

   assign src_cell_rdy = (unstarted > 0);
   assign src_word     = mem[rd_ptr[6:0]];

   always #(CLK_PERIOD/2) clk = ~clk;

   cro_rx_cell_out u0 (
      .clk(clk), .rst_n(rst_n), .src_cell_rdy(src_cell_rdy), .src_word(src_word),
      .src_pop(src_pop), .rx_en_n(rx_en_n), .rx_data(rx_data),
      .rx_soc(rx_soc), .rx_cav(rx_cav)
   );

   always @(posedge clk) begin
      if (src_pop) begin
         if (pop_idx == 0) unstarted <= unstarted - 1;
         rd_ptr  <= rd_ptr + 1;
         pop_idx <= (pop_idx == N-1) ? 0 : pop_idx + 1;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic logic [DW-1:0] wpat(int c, int k);
      return {4'h9, 8'(c), 8'(k), 16'h3c00 | 16'(k * 37 + c)};
   endfunction

   // called at a negedge
   task automatic push_cell(int c);
      for (int k = 0; k < N; k++) begin
         mem[wr_ptr[6:0]] = wpat(c, k);
         wr_ptr = wr_ptr + 1;
      end
      unstarted = unstarted + 1;
   endtask

   // advance to next negedge, drive enable, let logic settle
   task automatic step(bit en_low);
      @(negedge clk);
      rx_en_n = !en_low;
      #1;
   endtask

   task automatic expect_out(string req, bit ecav, bit esoc, bit ev, logic [DW-1:0] ew);
      logic [DW-1:0] ed;
      ed = ev ? ew : '0;
      checks = checks + 1;
      if (rx_cav !== ecav || rx_soc !== esoc || src_pop !== ev || rx_data !== ed) begin
         errors = errors + 1;
         $display("FAIL %s: actual cav=%b soc=%b pop=%b data=%h expected cav=%b soc=%b pop=%b data=%h",
                  req, rx_cav, rx_soc, src_pop, rx_data, ecav, esoc, ev, ed);
      end
   endtask

   // R1 / R9: reset state and idle bus
   task automatic t_reset();
      #1;
      expect_out("R1 in reset", 0, 0, 0, '0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      step(1);
      expect_out("R1 after reset", 0, 0, 0, '0);
      step(1); step(1);
      expect_out("R9 idle no cell, enable on", 0, 0, 0, '0);
   endtask

   // R2 R3 R5 R7 R8: enable held before cell-available
   task automatic t_enable_first(int c);
      push_cell(c);
      #1;
      expect_out("R2 not before edge", 0, 0, 0, '0);
      step(1);
      expect_out("R3 same-cycle first word", 1, 1, 1, wpat(c, 0));
      for (int k = 1; k < N; k++) begin
         step(1);
         expect_out("R7 word order", 1, 0, 1, wpat(c, k));
      end
      step(1);
      expect_out("R8 cav drops after last", 0, 0, 0, '0);
   endtask

   // R4 R9: cell-available before enable
   task automatic t_cav_first(int c);
      step(0);
      push_cell(c);
      step(0);
      expect_out("R9 cav up, enable off", 1, 0, 0, '0);
      step(0);
      expect_out("R9 waiting for enable", 1, 0, 0, '0);
      step(1);
      expect_out("R4 no word when enable first low", 1, 0, 0, '0);
      step(1);
      expect_out("R4 first word next cycle", 1, 1, 1, wpat(c, 0));
      for (int k = 1; k < N; k++) begin
         step(1);
         expect_out("R7 word order", 1, 0, 1, wpat(c, k));
      end
      step(1);
      expect_out("R8 cav drops", 0, 0, 0, '0);
   endtask

   // R6: mid-cell stall
   task automatic t_stall(int c);
      push_cell(c);
      step(1);
      expect_out("R6 word0", 1, 1, 1, wpat(c, 0));
      step(1);
      expect_out("R6 word1", 1, 0, 1, wpat(c, 1));
      step(0);
      expect_out("R6 stalled bus", 1, 0, 0, '0);
      step(0);
      expect_out("R6 still stalled", 1, 0, 0, '0);
      step(1);
      expect_out("R6 re-enable waits a cycle", 1, 0, 0, '0);
      for (int k = 2; k < N; k++) begin
         step(1);
         expect_out("R6 resumes with held word", 1, 0, 1, wpat(c, k));
      end
      step(1);
      expect_out("R8 cav drops", 0, 0, 0, '0);
   endtask

   // R8 R5: two cells back to back
   task automatic t_back_to_back(int c);
      push_cell(c);
      push_cell(c + 1);
      for (int j = 0; j < 2; j++) begin
         for (int k = 0; k < N; k++) begin
            step(1);
            expect_out(k == 0 ? "R5 soc on each cell" : "R8 no gap between cells",
                       1, k == 0, 1, wpat(c + j, k));
         end
      end
      step(1);
      expect_out("R8 cav drops after second cell", 0, 0, 0, '0);
   endtask

   initial begin
      t_reset();
      t_enable_first(1);
      t_cav_first(2);
      t_stall(3);
      t_back_to_back(4);
      step(1);
      expect_out("R9 final idle", 0, 0, 0, '0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule